// File: doc/BRIEF.md
# Fragment Identifier Consistency Checker

This block watches a stream of 32-bit event fragments and checks that the identifiers in each fragment header are consistent. Each fragment opens with a word that carries a start qualifier. Its header has a fixed layout: a start marker, a size word, then fields that include the extended event number in the sixth word and the bunch-crossing number in the seventh. Words after the seventh are payload, and the block passes over them.

Two checks are made on every well-formed header. First, the event and bunch numbers taken from the header are compared with values that a separate local counter supplies. That counter tracks trigger accepts and beam clocks on its own, and the block samples its values when the fragment starts. Second, the first fragment of each event sets a reference bunch number for that event, and every later fragment with the same event number must carry that same bunch number. A mismatch in either check usually means an accept was lost somewhere upstream.

Each error class gives a one-cycle pulse and has a saturating counter. A single strobe clears all the counters. The block does not store, forward or repair any data.

Top module: `fragment_id_checker`

## Requirements
- R1: While reset is high and in the first cycle after it, all three error pulses are 0 and all three counters read 0.
- R2: A word is accepted only when `valid_i` is 1. An accepted word with `sof_i`=1 is header word 1. Later accepted words with `sof_i`=0 are header words 2 to 7. The event number is the full header word 6. The bunch number is bits [BC_W-1:0] of header word 7, and the upper bits of that word are ignored. Accepted words after word 7 have no effect, and so do cycles with `valid_i`=0, whatever the data and `sof_i` lines carry.
- R3: In a well-formed header, if word 6 differs from `loc_evt_i` as sampled on word 1, `err_evt_o` is 1 for exactly one cycle. That cycle is the one after the clock edge that accepts word 7.
- R4: In a well-formed header, if the bunch number differs from `loc_bc_i` as sampled on word 1, `err_bc_o` pulses in that same cycle.
- R5: If a well-formed fragment has the same event number as the held reference event and a different bunch number, `err_bc_o` pulses even when the local bunch value matches.
- R6: A well-formed fragment whose event number differs from the held reference, or the first such fragment after reset, replaces the held reference event number and bunch number with its own values and raises no reference mismatch.
- R7: A header whose word 1 is not HDR_MARK, or whose word 2 is not 9, pulses `err_fmt_o` after word 7 is accepted. It raises no event or bunch pulse, and the held reference stays unchanged.
- R8: If a word with `sof_i`=1 is accepted after only 1 to 6 header words of a fragment, `err_fmt_o` pulses in the cycle after that word. The truncated fragment is not compared, and the new word starts a new fragment.
- R9: Each error pulse adds 1 to its class counter in the same cycle. A counter holds at 2^CNT_W-1 and does not wrap. Without a pulse, a counter does not change.
- R10: A `clr_i` strobe sets all three counters to 0 in the next cycle. When an increment falls on the same edge, the clear wins, but the error pulse is still given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| word_i | input | DATA_W | Fragment stream word |
| sof_i | input | 1 | Marks the first word of a fragment |
| valid_i | input | 1 | Word qualifier |
| loc_evt_i | input | DATA_W | Locally counted extended event number |
| loc_bc_i | input | BC_W | Locally counted bunch-crossing number |
| clr_i | input | 1 | Clears all error counters |
| err_evt_o | output | 1 | Event number mismatch pulse |
| err_bc_o | output | 1 | Bunch number mismatch pulse |
| err_fmt_o | output | 1 | Header format error pulse |
| cnt_evt_o | output | CNT_W | Event mismatch count |
| cnt_bc_o | output | CNT_W | Bunch mismatch count |
| cnt_fmt_o | output | CNT_W | Format error count |

## Verification
Some properties are checked by assertions on every cycle. Each counter moves only with its own pulse or with a clear, it steps by exactly one, and it never goes down except on a clear. Pulses appear only after an accepted word, and a format error never coincides with an identifier error. Only the bench scenarios can show that the right class fires for a given header. This covers header field positions, intra-event bunch consistency and reference replacement, format errors on the marker, size and truncation, gaps in the valid signal, and the rule that a clear beats an increment on the same edge.

// File: rtl/fic_pkg.sv
package fic_pkg;
  // header layout, counted from 1
  localparam int HDR_SIZE_VAL = 9;
  localparam int POS_SIZE     = 2;
  localparam int POS_EVT      = 6;
  localparam int POS_BC       = 7;
  localparam int IDX_W        = 3;

  // error class slots
  localparam int NUM_ERR = 3;
  typedef enum logic [1:0] {
    ERR_EVT = 2'd0,
    ERR_BC  = 2'd1,
    ERR_FMT = 2'd2
  } err_cls_e;
endpackage

// File: rtl/fic_hdr_parse.sv
module fic_hdr_parse
  import fic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BC_W = 12,
  parameter logic [DATA_W-1:0] HDR_MARK = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word_i,
  input  logic              sof_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] loc_evt_i,
  input  logic [BC_W-1:0]   loc_bc_i,
  output logic              done_o,
  output logic              fmt_err_o,
  output logic [DATA_W-1:0] evt_o,
  output logic [BC_W-1:0]   bc_o,
  output logic [DATA_W-1:0] lref_evt_o,
  output logic [BC_W-1:0]   lref_bc_o
);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(POS_BC);

  // number of header words accepted so far (saturates at IDX_LAST)
  logic [IDX_W-1:0]  idx_q;
  logic              bad_q;
  logic [DATA_W-1:0] evt_q;
  logic [DATA_W-1:0] lref_evt_q;
  logic [BC_W-1:0]   lref_bc_q;

  logic start, in_hdr, cont, last_word, size_bad;

  always_comb begin
    start     = valid_i && sof_i;
    in_hdr    = (idx_q != '0) && (idx_q < IDX_LAST);
    cont      = valid_i && !sof_i && in_hdr;
    last_word = cont && (idx_q == IDX_W'(POS_BC - 1));
    size_bad  = cont && (idx_q == IDX_W'(POS_SIZE - 1)) &&
                (word_i != DATA_W'(HDR_SIZE_VAL));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q      <= '0;
      bad_q      <= 1'b0;
      evt_q      <= '0;
      lref_evt_q <= '0;
      lref_bc_q  <= '0;
    end else if (start) begin
      idx_q      <= IDX_W'(1);
      bad_q      <= (word_i != HDR_MARK);
      lref_evt_q <= loc_evt_i;
      lref_bc_q  <= loc_bc_i;
    end else if (cont) begin
      idx_q <= idx_q + IDX_W'(1);
      if (size_bad) bad_q <= 1'b1;
      if (idx_q == IDX_W'(POS_EVT - 1)) evt_q <= word_i;
    end
  end

  always_comb begin
    done_o     = last_word && !bad_q;
    fmt_err_o  = (start && in_hdr) || (last_word && bad_q);
    evt_o      = evt_q;
    bc_o       = word_i[BC_W-1:0];
    lref_evt_o = lref_evt_q;
    lref_bc_o  = lref_bc_q;
  end
endmodule

// File: rtl/fic_compare.sv
module fic_compare #(
  parameter int DATA_W = 32,
  parameter int BC_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              done_i,
  input  logic [DATA_W-1:0] evt_i,
  input  logic [BC_W-1:0]   bc_i,
  input  logic [DATA_W-1:0] lref_evt_i,
  input  logic [BC_W-1:0]   lref_bc_i,
  output logic              evt_mis_o,
  output logic              bc_mis_o
);
  logic              have_q;
  logic [DATA_W-1:0] cur_evt_q;
  logic [BC_W-1:0]   cur_bc_q;
  logic              same_evt;

  always_comb begin
    same_evt  = have_q && (evt_i == cur_evt_q);
    evt_mis_o = done_i && (evt_i != lref_evt_i);
    bc_mis_o  = done_i && ((bc_i != lref_bc_i) ||
                           (same_evt && (bc_i != cur_bc_q)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      have_q    <= 1'b0;
      cur_evt_q <= '0;
      cur_bc_q  <= '0;
    end else if (done_i && !same_evt) begin
      have_q    <= 1'b1;
      cur_evt_q <= evt_i;
      cur_bc_q  <= bc_i;
    end
  end
endmodule

// File: rtl/fic_sat_cnt.sv
module fic_sat_cnt #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] MAX = '1;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clr_i)                cnt_q <= '0;
    else if (inc_i && cnt_q != MAX) cnt_q <= cnt_q + W'(1);
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/fragment_id_checker.sv
module fragment_id_checker
  import fic_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BC_W = 12,
  parameter int CNT_W = 16,
  parameter logic [DATA_W-1:0] HDR_MARK = 32'hA5C3_0F1E
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] word_i,
  input  logic              sof_i,
  input  logic              valid_i,
  input  logic [DATA_W-1:0] loc_evt_i,
  input  logic [BC_W-1:0]   loc_bc_i,
  input  logic              clr_i,
  output logic              err_evt_o,
  output logic              err_bc_o,
  output logic              err_fmt_o,
  output logic [CNT_W-1:0]  cnt_evt_o,
  output logic [CNT_W-1:0]  cnt_bc_o,
  output logic [CNT_W-1:0]  cnt_fmt_o
);
  logic              done, fmt_err, evt_mis, bc_mis;
  logic [DATA_W-1:0] hdr_evt, lref_evt;
  logic [BC_W-1:0]   hdr_bc, lref_bc;
  logic [NUM_ERR-1:0] err_req, err_q;
  logic [CNT_W-1:0]  cnt_arr [NUM_ERR];

  fic_hdr_parse #(.DATA_W(DATA_W), .BC_W(BC_W), .HDR_MARK(HDR_MARK)) u_parse (
    .clk(clk), .rst(rst), .word_i(word_i), .sof_i(sof_i), .valid_i(valid_i),
    .loc_evt_i(loc_evt_i), .loc_bc_i(loc_bc_i),
    .done_o(done), .fmt_err_o(fmt_err), .evt_o(hdr_evt), .bc_o(hdr_bc),
    .lref_evt_o(lref_evt), .lref_bc_o(lref_bc)
  );

  fic_compare #(.DATA_W(DATA_W), .BC_W(BC_W)) u_cmp (
    .clk(clk), .rst(rst), .done_i(done), .evt_i(hdr_evt), .bc_i(hdr_bc),
    .lref_evt_i(lref_evt), .lref_bc_i(lref_bc),
    .evt_mis_o(evt_mis), .bc_mis_o(bc_mis)
  );

  always_comb begin
    err_req          = '0;
    err_req[ERR_EVT] = evt_mis;
    err_req[ERR_BC]  = bc_mis;
    err_req[ERR_FMT] = fmt_err;
  end

  always_ff @(posedge clk) begin
    if (rst) err_q <= '0;
    else     err_q <= err_req;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_cnt
    fic_sat_cnt #(.W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst), .clr_i(clr_i), .inc_i(err_req[g]), .cnt_o(cnt_arr[g])
    );
  end

  assign err_evt_o = err_q[ERR_EVT];
  assign err_bc_o  = err_q[ERR_BC];
  assign err_fmt_o = err_q[ERR_FMT];
  assign cnt_evt_o = cnt_arr[ERR_EVT];
  assign cnt_bc_o  = cnt_arr[ERR_BC];
  assign cnt_fmt_o = cnt_arr[ERR_FMT];
endmodule

// File: rtl/fic_check.sv
module fic_check #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             valid_i,
  input logic             clr_i,
  input logic             err_evt_o,
  input logic             err_bc_o,
  input logic             err_fmt_o,
  input logic [CNT_W-1:0] cnt_evt_o,
  input logic [CNT_W-1:0] cnt_bc_o,
  input logic [CNT_W-1:0] cnt_fmt_o
);
  localparam logic [CNT_W-1:0] MAX = '1;

  AST_EVT_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (err_evt_o && !$past(clr_i) && $past(cnt_evt_o) != MAX) |-> cnt_evt_o == $past(cnt_evt_o) + CNT_W'(1)); // R9
  AST_BC_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (err_bc_o && !$past(clr_i) && $past(cnt_bc_o) != MAX) |-> cnt_bc_o == $past(cnt_bc_o) + CNT_W'(1)); // R9
  AST_FMT_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (err_fmt_o && !$past(clr_i) && $past(cnt_fmt_o) != MAX) |-> cnt_fmt_o == $past(cnt_fmt_o) + CNT_W'(1)); // R9
  AST_CNT_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!$past(clr_i) && !err_evt_o && !err_bc_o && !err_fmt_o) |->
      ($stable(cnt_evt_o) && $stable(cnt_bc_o) && $stable(cnt_fmt_o))); // R9
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    $past(clr_i) |-> (cnt_evt_o == '0 && cnt_bc_o == '0 && cnt_fmt_o == '0)); // R10
  AST_PULSE_NEEDS_WORD: assert property (@(posedge clk) disable iff (rst)
    (err_evt_o || err_bc_o || err_fmt_o) |-> $past(valid_i)); // R2
  AST_FMT_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    err_fmt_o |-> (!err_evt_o && !err_bc_o)); // R7
endmodule

bind fragment_id_checker fic_check #(.CNT_W(CNT_W)) u_fic_check (
  .clk(clk), .rst(rst), .valid_i(valid_i), .clr_i(clr_i),
  .err_evt_o(err_evt_o), .err_bc_o(err_bc_o), .err_fmt_o(err_fmt_o),
  .cnt_evt_o(cnt_evt_o), .cnt_bc_o(cnt_bc_o), .cnt_fmt_o(cnt_fmt_o)
);

// File: tb/test_fragment_id_checker.sv
`timescale 1ns/1ps
module test_fragment_id_checker;
  localparam int DW = 32;
  localparam int BW = 12;
  localparam int CW = 4;
  localparam logic [31:0] MARK = 32'hA5C3_0F1E;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [DW-1:0] word_i = '0;
  logic sof_i = 1'b0, valid_i = 1'b0, clr_i = 1'b0;
  logic [DW-1:0] loc_evt_i = '0;
  logic [BW-1:0] loc_bc_i = '0;
  logic err_evt_o, err_bc_o, err_fmt_o;
  logic [CW-1:0] cnt_evt_o, cnt_bc_o, cnt_fmt_o;

  int n_chk = 0;
  int n_bad = 0;
  int e_evt = 0, e_bc = 0, e_fmt = 0;

  always #2.5 clk = ~clk;

  fragment_id_checker #(.DATA_W(DW), .BC_W(BW), .CNT_W(CW), .HDR_MARK(MARK)) i_fragment_id_checker (
    .clk(clk), .rst(rst), .word_i(word_i), .sof_i(sof_i), .valid_i(valid_i),
    .loc_evt_i(loc_evt_i), .loc_bc_i(loc_bc_i), .clr_i(clr_i),
    .err_evt_o(err_evt_o), .err_bc_o(err_bc_o), .err_fmt_o(err_fmt_o),
    .cnt_evt_o(cnt_evt_o), .cnt_bc_o(cnt_bc_o), .cnt_fmt_o(cnt_fmt_o)
  );

  typedef struct packed {
    logic [31:0] mark;
    logic [31:0] size;
    logic [31:0] evt;
    logic [31:0] bcw;
    logic [31:0] levt;
    logic [11:0] lbc;
    logic        x_evt;
    logic        x_bc;
    logic        x_fmt;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VEC [NV] = '{
    '{MARK, 32'd9, 32'h0000_0000, 32'h0000_0010, 32'h0000_0000, 12'h010, 1'b0, 1'b0, 1'b0}, // R6 first event
    '{MARK, 32'd9, 32'h0000_0000, 32'h0000_0010, 32'h0000_0000, 12'h010, 1'b0, 1'b0, 1'b0}, // R5 consistent
    '{MARK, 32'd9, 32'h0000_0000, 32'h0000_0011, 32'h0000_0000, 12'h011, 1'b0, 1'b1, 1'b0}, // R5 intra-event
    '{MARK, 32'd9, 32'h0000_0001, 32'h0000_0020, 32'h0000_0001, 12'h020, 1'b0, 1'b0, 1'b0}, // R6 new event
    '{MARK, 32'd9, 32'h0000_0001, 32'h0000_0020, 32'h0000_0002, 12'h020, 1'b1, 1'b0, 1'b0}, // R3
    '{MARK, 32'd9, 32'h0000_0001, 32'h0000_0020, 32'h0000_0001, 12'h021, 1'b0, 1'b1, 1'b0}, // R4
    '{MARK, 32'd8, 32'h0000_0001, 32'h0000_0099, 32'h0000_0001, 12'h099, 1'b0, 1'b0, 1'b1}, // R7 size
    '{32'h1234_5678, 32'd9, 32'h0000_0001, 32'h0000_0055, 32'h0000_0001, 12'h055, 1'b0, 1'b0, 1'b1}, // R7 marker
    '{MARK, 32'd9, 32'h0000_0001, 32'h0000_0020, 32'h0000_0001, 12'h020, 1'b0, 1'b0, 1'b0}, // R7 ref kept
    '{MARK, 32'd9, 32'h0100_0003, 32'hFFFF_F020, 32'h0100_0003, 12'h020, 1'b0, 1'b0, 1'b0}, // R2 upper bits
    '{MARK, 32'd9, 32'h0100_0003, 32'h0000_07FF, 32'h0100_0004, 12'h7FF, 1'b1, 1'b1, 1'b0}  // R3 R4 R5
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] w, input logic s, input logic gap);
    @(negedge clk);
    word_i = w; sof_i = s; valid_i = 1'b1;
    if (gap) begin
      @(negedge clk);
      word_i = 32'hFFFF_FFFF; sof_i = 1'b1; valid_i = 1'b0;
    end
  endtask

  // drives header words 1..7; the caller samples at the next negedge
  task automatic send_hdr(input vec_t v, input logic gap);
    loc_evt_i = v.levt; loc_bc_i = v.lbc;
    put(v.mark, 1'b1, gap);
    put(v.size, 1'b0, gap);
    put(32'h0000_0001, 1'b0, gap);
    put(32'h0000_0002, 1'b0, gap);
    put(32'h0000_0003, 1'b0, gap);
    put(v.evt, 1'b0, gap);
    put(v.bcw, 1'b0, 1'b0);
  endtask

  task automatic payload();
    put(32'h0000_0009, 1'b0, 1'b0);
    put(32'hDEAD_BEEF, 1'b0, 1'b0);
    @(negedge clk);
    valid_i = 1'b0; loc_evt_i = 32'h7777_7777; loc_bc_i = 12'h777;
  endtask

  task automatic check_cnts(input string req);
    check({req, " cnt_evt"}, 32'(cnt_evt_o), 32'(e_evt));
    check({req, " cnt_bc"},  32'(cnt_bc_o),  32'(e_bc));
    check({req, " cnt_fmt"}, 32'(cnt_fmt_o), 32'(e_fmt));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 pulses", {29'd0, err_evt_o, err_bc_o, err_fmt_o}, 32'd0);
    check_cnts("R1");
    rst = 1'b0;
    // R2: stray words before any start are ignored
    put(32'h0000_0009, 1'b0, 1'b0);
    put(32'h0000_0000, 1'b0, 1'b0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R1 R2 idle pulses", {29'd0, err_evt_o, err_bc_o, err_fmt_o}, 32'd0);
    check_cnts("R1 R2");

    for (int i = 0; i < NV; i++) begin
      send_hdr(VEC[i], 1'b0);
      @(negedge clk);
      check($sformatf("R3 vec%0d evt", i), 32'(err_evt_o), 32'(VEC[i].x_evt));
      check($sformatf("R4 R5 vec%0d bc", i), 32'(err_bc_o), 32'(VEC[i].x_bc));
      check($sformatf("R7 vec%0d fmt", i), 32'(err_fmt_o), 32'(VEC[i].x_fmt));
      e_evt += int'(VEC[i].x_evt); e_bc += int'(VEC[i].x_bc); e_fmt += int'(VEC[i].x_fmt);
      payload();
      check_cnts($sformatf("R9 vec%0d", i));
    end

    // R8: truncated header, then a new fragment starting at once
    loc_evt_i = 32'h0100_0003; loc_bc_i = 12'h020;
    put(MARK, 1'b1, 1'b0);
    put(32'd9, 1'b0, 1'b0);
    put(32'h0000_0001, 1'b0, 1'b0);
    put(MARK, 1'b1, 1'b0);
    @(negedge clk);
    check("R8 trunc fmt", 32'(err_fmt_o), 32'd1);
    check("R8 trunc evt", 32'(err_evt_o), 32'd0);
    e_fmt++;
    word_i = 32'd9; sof_i = 1'b0;
    put(32'h0000_0001, 1'b0, 1'b0);
    put(32'h0000_0002, 1'b0, 1'b0);
    put(32'h0000_0003, 1'b0, 1'b0);
    put(32'h0100_0003, 1'b0, 1'b0);
    put(32'h0000_0020, 1'b0, 1'b0);
    @(negedge clk);
    check("R8 restart clean", {29'd0, err_evt_o, err_bc_o, err_fmt_o}, 32'd0);
    payload();
    check_cnts("R8");

    // R2: gaps with valid low carry junk and sof; good fragment
    send_hdr('{MARK, 32'd9, 32'h0100_0003, 32'h0000_0020, 32'h0100_0003, 12'h020, 1'b0, 1'b0, 1'b0}, 1'b1);
    @(negedge clk);
    check("R2 gaps clean", {29'd0, err_evt_o, err_bc_o, err_fmt_o}, 32'd0);
    payload();
    check_cnts("R2 gaps");

    // R10: clear on the same edge as an event error increment
    loc_evt_i = 32'h0000_0050; loc_bc_i = 12'h020;
    put(MARK, 1'b1, 1'b0);
    put(32'd9, 1'b0, 1'b0);
    put(32'h0000_0001, 1'b0, 1'b0);
    put(32'h0000_0002, 1'b0, 1'b0);
    put(32'h0000_0003, 1'b0, 1'b0);
    put(32'h0100_0003, 1'b0, 1'b0);
    put(32'h0000_0020, 1'b0, 1'b0);
    clr_i = 1'b1;
    @(negedge clk);
    clr_i = 1'b0; valid_i = 1'b0;
    check("R10 pulse kept", 32'(err_evt_o), 32'd1);
    e_evt = 0; e_bc = 0; e_fmt = 0;
    check_cnts("R10 clear wins");

    // R9: saturation with back-to-back truncating starts
    put(MARK, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) put(MARK, 1'b1, 1'b0);
    @(negedge clk);
    valid_i = 1'b0;
    check("R9 pulse at max", 32'(err_fmt_o), 32'd1);
    e_fmt = 15;
    check_cnts("R9 saturate");
    @(negedge clk);
    check("R9 hold", 32'(cnt_fmt_o), 32'd15);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule